// File: doc/BRIEF.md
# Macro Result Dispatch and Method Emitter

This block takes the outcome of one executed macro instruction and carries out its result mode. It receives a 32-bit result word, a destination register index and a 3-bit mode. From these it decides what goes back to the destination register. It also decides whether the next queued parameter is consumed, whether the method register is reloaded, and whether a method write leaves the block.

The block holds a parameter queue that the surrounding sequencer fills before and during a macro run. It also holds a method register made of a 12-bit address and a 6-bit stride. Each emitted method write carries the current address, and the address then steps forward by the stride, wrapping modulo 4096. A `start` pulse begins a new macro: it empties the queue and clears the method register.

All outputs are registered. The effects of an instruction presented in one cycle appear in the cycle after it.

Top module: `mres_dispatch`

## Requirements
- R1: After reset, and after a `start` pulse, the block drives no register write, no method write and no error, and the method address and stride are both zero.
- R2: Mode 0 writes the next queued parameter to the destination, discards the result, and emits no method write.
- R3: Mode 1 writes the result to the destination. It leaves the method register unchanged and emits no method write.
- R4: Mode 2 writes the result to the destination and loads the method register from it: address from result bits [11:0], stride from result bits [17:12]. It emits no method write.
- R5: Mode 3 writes the next queued parameter to the destination and emits a method write whose data is the result.
- R6: Mode 4 writes the result to the destination and emits a method write whose data is the result.
- R7: Mode 5 writes the next queued parameter to the destination and loads the method register from the result. It emits no method write.
- R8: Mode 6 writes the result to the destination and loads the method register from it. It then consumes the next queued parameter and emits it as method data at the newly loaded address.
- R9: Mode 7 writes the result to the destination and loads the method register from it. It emits result bits [17:12], zero-extended, as method data at the newly loaded address.
- R10: Every method write carries the current method address, and the address then advances by the stride modulo 4096. There is at most one method write per instruction, shown as a one-cycle `mw_valid` pulse in the cycle after the instruction.
- R11: When the destination index is 0, no register write strobe is raised. The mode's other effects (sending, method loading, parameter consumption) still take place.
- R12: Consuming a parameter from an empty queue raises `prm_err` for one cycle. It supplies zero as the parameter value and does not move the read position, so a parameter pushed later is the next one consumed.
- R13: Parameters leave the queue in push order. A `start` pulse discards any parameters still queued.
- R14: A push into a full queue (DEPTH entries) is ignored. The queued contents stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new macro: empty the queue and clear the method register |
| prm_push | input | 1 | Append `prm_data` to the parameter queue |
| prm_data | input | DW | Parameter word to append |
| instr_valid | input | 1 | An instruction result is presented this cycle |
| res | input | DW | Instruction result word |
| dst | input | RW | Destination register index |
| mode | input | 3 | Result mode 0..7 |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | RW | Register write index |
| rf_wdata | output | DW | Register write data |
| mw_valid | output | 1 | Method write pulse |
| mw_addr | output | AW | Method write address |
| mw_data | output | DW | Method write data |
| prm_err | output | 1 | Parameter consumed from an empty queue |

## Verification
Every one of the eight modes is driven with results whose address, stride and upper bits are all distinct. This shows which value reached the destination (result versus parameter) and which reached the method data (result, parameter or stride field). A plain send with mode 4 follows each load, so the loaded address and stride are read back at the ports. Stride values that carry the address past 4095 show the wrap. Pushes into a full queue, consumption from an empty queue and a mid-run `start` show the queue's edges, with the consumed value serving as the witness.

// File: rtl/mres_pkg.sv
package mres_pkg;

  typedef enum logic [2:0] {
    RM_FETCH            = 3'd0,
    RM_MOVE             = 3'd1,
    RM_MOVE_SETM        = 3'd2,
    RM_FETCH_SEND       = 3'd3,
    RM_MOVE_SEND        = 3'd4,
    RM_FETCH_SETM       = 3'd5,
    RM_MOVE_SETM_PSEND  = 3'd6,
    RM_MOVE_SETM_FSEND  = 3'd7
  } rmode_e;

  typedef enum logic [1:0] {
    SD_RESULT = 2'd0,
    SD_PARAM  = 2'd1,
    SD_FIELD  = 2'd2
  } sdsel_e;

  typedef struct packed {
    logic   dst_param;
    logic   pop;
    logic   set_m;
    logic   send;
    sdsel_e sel;
  } rctl_t;

  function automatic rctl_t decode_mode(input logic [2:0] m);
    rctl_t c;
    c = '{dst_param: 1'b0, pop: 1'b0, set_m: 1'b0, send: 1'b0, sel: SD_RESULT};
    unique case (rmode_e'(m))
      RM_FETCH:           begin c.dst_param = 1'b1; c.pop = 1'b1; end
      RM_MOVE:            ;
      RM_MOVE_SETM:       c.set_m = 1'b1;
      RM_FETCH_SEND:      begin c.dst_param = 1'b1; c.pop = 1'b1; c.send = 1'b1; end
      RM_MOVE_SEND:       c.send = 1'b1;
      RM_FETCH_SETM:      begin c.dst_param = 1'b1; c.pop = 1'b1; c.set_m = 1'b1; end
      RM_MOVE_SETM_PSEND: begin c.pop = 1'b1; c.set_m = 1'b1; c.send = 1'b1; c.sel = SD_PARAM; end
      RM_MOVE_SETM_FSEND: begin c.set_m = 1'b1; c.send = 1'b1; c.sel = SD_FIELD; end
      default:            ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mres_param_buf.sv
module mres_param_buf #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic          underflow
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          empty, full, push_ok, pop_ok;

  assign empty   = (cnt == '0);
  assign full    = (cnt == FULL_CNT);
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;

  assign pop_data  = empty ? '0 : mem[rd_ptr];
  assign underflow = pop && empty;

  // Storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R12: an empty pop leaves the read position where it was
  assert_pop_empty_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !clr) |=> $stable(rd_ptr));

  // R14: a push into a full queue does not grow it
  assert_full_push_ignored_R14: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !clr) |=> (cnt == FULL_CNT));

  // R13: count never exceeds capacity
  assert_cnt_bound_R13: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL_CNT);

endmodule

// File: rtl/mres_method_reg.sv
module mres_method_reg #(
  parameter int DW = 32,
  parameter int AW = 12,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          adv,
  output logic [AW-1:0] send_addr
);
  logic [AW-1:0] addr_q;
  logic [IW-1:0] inc_q;
  logic [AW-1:0] eff_addr;
  logic [IW-1:0] eff_inc;

  assign eff_addr  = load ? load_val[AW-1:0]      : addr_q;
  assign eff_inc   = load ? load_val[AW+IW-1:AW]  : inc_q;
  assign send_addr = eff_addr;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      addr_q <= '0;
      inc_q  <= '0;
    end else if (load || adv) begin
      addr_q <= adv ? eff_addr + AW'(eff_inc) : eff_addr;
      inc_q  <= eff_inc;
    end
  end

  // R10: a send without a reload steps the address by the stride, modulo 2^AW
  assert_stride_step_R10: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && !clr) |=> (addr_q == AW'($past(addr_q) + AW'($past(inc_q)))));

  // R3: with neither load nor send the register holds
  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!adv && !load && !clr) |=> ($stable(addr_q) && $stable(inc_q)));

endmodule

// File: rtl/mres_dispatch.sv
module mres_dispatch #(
  parameter int DW    = 32,
  parameter int RW    = 3,
  parameter int AW    = 12,
  parameter int IW    = 6,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          prm_push,
  input  logic [DW-1:0] prm_data,
  input  logic          instr_valid,
  input  logic [DW-1:0] res,
  input  logic [RW-1:0] dst,
  input  logic [2:0]    mode,
  output logic          rf_we,
  output logic [RW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic          mw_valid,
  output logic [AW-1:0] mw_addr,
  output logic [DW-1:0] mw_data,
  output logic          prm_err
);
  import mres_pkg::*;

  rctl_t         ctl;
  logic          act, pop, load, adv, underflow;
  logic [DW-1:0] pop_data, wb_val, snd_val;
  logic [AW-1:0] send_addr;

  assign ctl  = decode_mode(mode);
  assign act  = instr_valid && !start;
  assign pop  = act && ctl.pop;
  assign load = act && ctl.set_m;
  assign adv  = act && ctl.send;

  mres_param_buf #(.DW(DW), .DEPTH(DEPTH)) u_pbuf (
    .clk       (clk),
    .rst       (rst),
    .clr       (start),
    .push      (prm_push),
    .push_data (prm_data),
    .pop       (pop),
    .pop_data  (pop_data),
    .underflow (underflow)
  );

  mres_method_reg #(.DW(DW), .AW(AW), .IW(IW)) u_mreg (
    .clk       (clk),
    .rst       (rst),
    .clr       (start),
    .load      (load),
    .load_val  (res),
    .adv       (adv),
    .send_addr (send_addr)
  );

  assign wb_val = ctl.dst_param ? pop_data : res;

  always_comb begin
    unique case (ctl.sel)
      SD_PARAM: snd_val = pop_data;
      SD_FIELD: snd_val = DW'(res[AW+IW-1:AW]);
      default:  snd_val = res;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_we    <= 1'b0;
      rf_waddr <= '0;
      rf_wdata <= '0;
      mw_valid <= 1'b0;
      mw_addr  <= '0;
      mw_data  <= '0;
      prm_err  <= 1'b0;
    end else begin
      rf_we    <= act && (dst != '0);
      rf_waddr <= dst;
      rf_wdata <= wb_val;
      mw_valid <= adv;
      mw_addr  <= send_addr;
      mw_data  <= snd_val;
      prm_err  <= pop && underflow;
    end
  end

  // R11: register 0 is never written
  assert_no_r0_write_R11: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_waddr != '0));

  // R10: a method write only follows a presented instruction, and lasts one cycle unless one follows
  assert_send_follows_instr_R10: assert property (@(posedge clk) disable iff (rst)
    mw_valid |-> $past(instr_valid));

  // R12: an error only follows an instruction that consumes a parameter
  assert_err_follows_pop_R12: assert property (@(posedge clk) disable iff (rst)
    prm_err |-> ($past(instr_valid) && $past(mode) != 3'd1 && $past(mode) != 3'd2
                 && $past(mode) != 3'd4 && $past(mode) != 3'd7));

  // R1: a start cycle produces no outputs in the following cycle
  assert_start_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    start |=> (!rf_we && !mw_valid && !prm_err));

endmodule

// File: tb/test_mres_dispatch.sv
module test_mres_dispatch;
  localparam int DW = 32, RW = 3, AW = 12, IW = 6, DEPTH = 16;

  logic          clk = 1'b0;
  logic          rst, start, prm_push, instr_valid;
  logic [DW-1:0] prm_data, res;
  logic [RW-1:0] dst;
  logic [2:0]    mode;
  logic          rf_we, mw_valid, prm_err;
  logic [RW-1:0] rf_waddr;
  logic [DW-1:0] rf_wdata, mw_data;
  logic [AW-1:0] mw_addr;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  mres_dispatch #(.DW(DW), .RW(RW), .AW(AW), .IW(IW), .DEPTH(DEPTH)) i_mres_dispatch (
    .clk(clk), .rst(rst), .start(start), .prm_push(prm_push), .prm_data(prm_data),
    .instr_valid(instr_valid), .res(res), .dst(dst), .mode(mode),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mw_valid(mw_valid), .mw_addr(mw_addr), .mw_data(mw_data), .prm_err(prm_err)
  );

  task automatic expect_out(input string tag, input logic we, input logic [RW-1:0] wa,
                            input logic [DW-1:0] wd, input logic mv, input logic [AW-1:0] ma,
                            input logic [DW-1:0] md, input logic er);
    logic ok;
    ok = (rf_we === we) && (mw_valid === mv) && (prm_err === er);
    if (we) ok = ok && (rf_waddr === wa) && (rf_wdata === wd);
    if (mv) ok = ok && (mw_addr === ma) && (mw_data === md);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual we=%0b wa=%0d wd=%h mv=%0b ma=%h md=%h err=%0b expected we=%0b wa=%0d wd=%h mv=%0b ma=%h md=%h err=%0b",
               tag, rf_we, rf_waddr, rf_wdata, mw_valid, mw_addr, mw_data, prm_err,
               we, wa, wd, mv, ma, md, er);
    end
  endtask

  task automatic exec(input logic [2:0] m, input logic [RW-1:0] d, input logic [DW-1:0] r);
    @(negedge clk);
    mode = m; dst = d; res = r; instr_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic push(input logic [DW-1:0] v);
    @(negedge clk);
    prm_push = 1'b1; prm_data = v;
    @(posedge clk);
    @(negedge clk);
    prm_push = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    expect_out("R1 quiet after start", 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_reset();
    expect_out("R1 reset outputs", 0, 0, 0, 0, 0, 0, 0);
    exec(3'd4, 3'd2, 32'h55);
    expect_out("R1 R6 send at reset address 0", 1, 2, 32'h55, 1, 12'h000, 32'h55, 0);
    exec(3'd4, 3'd2, 32'h56);
    expect_out("R1 stride zero after reset", 1, 2, 32'h56, 1, 12'h000, 32'h56, 0);
  endtask

  task automatic t_mode0();
    push(32'hA1); push(32'hA2); push(32'hA3);
    exec(3'd0, 3'd3, 32'hDEAD);
    expect_out("R2 mode0 pops first param R13", 1, 3, 32'hA1, 0, 0, 0, 0);
  endtask

  task automatic t_mode1();
    exec(3'd1, 3'd4, 32'h0003_1234);
    expect_out("R3 mode1 moves result", 1, 4, 32'h0003_1234, 0, 0, 0, 0);
    exec(3'd4, 3'd1, 32'h5);
    expect_out("R3 method unchanged by mode1", 1, 1, 32'h5, 1, 12'h000, 32'h5, 0);
  endtask

  task automatic t_mode2();
    exec(3'd2, 3'd5, 32'h0000_3100);
    expect_out("R4 mode2 moves, no send", 1, 5, 32'h3100, 0, 0, 0, 0);
    exec(3'd4, 3'd1, 32'h7);
    expect_out("R4 loaded address", 1, 1, 32'h7, 1, 12'h100, 32'h7, 0);
    exec(3'd4, 3'd1, 32'h8);
    expect_out("R10 stride 3 step", 1, 1, 32'h8, 1, 12'h103, 32'h8, 0);
  endtask

  task automatic t_mode3();
    exec(3'd3, 3'd2, 32'h77);
    expect_out("R5 mode3 param to dst, send result", 1, 2, 32'hA2, 1, 12'h106, 32'h77, 0);
  endtask

  task automatic t_mode5();
    exec(3'd5, 3'd6, 32'h0000_1200);
    expect_out("R7 mode5 param to dst, no send", 1, 6, 32'hA3, 0, 0, 0, 0);
    exec(3'd4, 3'd1, 32'h9);
    expect_out("R7 loaded address", 1, 1, 32'h9, 1, 12'h200, 32'h9, 0);
  endtask

  task automatic t_mode6();
    push(32'hB1);
    exec(3'd6, 3'd1, 32'h0000_2300);
    expect_out("R8 mode6 sends popped param at new address", 1, 1, 32'h2300, 1, 12'h300, 32'hB1, 0);
    exec(3'd4, 3'd1, 32'hA);
    expect_out("R8 stride loaded by mode6", 1, 1, 32'hA, 1, 12'h302, 32'hA, 0);
  endtask

  task automatic t_mode7();
    exec(3'd7, 3'd7, 32'hF003_5ABC);
    expect_out("R9 mode7 sends stride field", 1, 7, 32'hF003_5ABC, 1, 12'hABC, 32'h35, 0);
    exec(3'd4, 3'd1, 32'hB);
    expect_out("R9 address after mode7 send", 1, 1, 32'hB, 1, 12'hAF1, 32'hB, 0);
  endtask

  task automatic t_wrap();
    exec(3'd2, 3'd1, 32'h0003_FFF0);
    expect_out("R4 load near top", 1, 1, 32'h3FFF0, 0, 0, 0, 0);
    exec(3'd4, 3'd1, 32'h1);
    expect_out("R10 send before wrap", 1, 1, 32'h1, 1, 12'hFF0, 32'h1, 0);
    exec(3'd4, 3'd1, 32'h2);
    expect_out("R10 address wraps modulo 4096", 1, 1, 32'h2, 1, 12'h02F, 32'h2, 0);
  endtask

  task automatic t_r0();
    exec(3'd4, 3'd0, 32'h99);
    expect_out("R11 dst 0 no write, send kept", 0, 0, 0, 1, 12'h06E, 32'h99, 0);
    push(32'hC0);
    exec(3'd0, 3'd0, 32'h0);
    expect_out("R11 dst 0 no write on fetch", 0, 0, 0, 0, 0, 0, 0);
    exec(3'd0, 3'd3, 32'h0);
    expect_out("R11 fetch with dst 0 still consumed", 1, 3, 32'h0, 0, 0, 0, 1);
  endtask

  task automatic t_underflow();
    exec(3'd0, 3'd2, 32'h1234);
    expect_out("R12 empty pop error", 1, 2, 32'h0, 0, 0, 0, 1);
    push(32'hC1);
    exec(3'd0, 3'd2, 32'h1234);
    expect_out("R12 read position held", 1, 2, 32'hC1, 0, 0, 0, 0);
  endtask

  task automatic t_start();
    push(32'hD1); push(32'hD2);
    pulse_start();
    push(32'hE1);
    exec(3'd0, 3'd4, 32'h0);
    expect_out("R13 start discards queued params", 1, 4, 32'hE1, 0, 0, 0, 0);
    exec(3'd4, 3'd4, 32'h3);
    expect_out("R1 method cleared by start", 1, 4, 32'h3, 1, 12'h000, 32'h3, 0);
  endtask

  task automatic t_full();
    pulse_start();
    for (int i = 0; i <= DEPTH; i++) push(32'h100 + i);
    for (int i = 0; i < DEPTH; i++) begin
      exec(3'd0, 3'd5, 32'h0);
      expect_out("R14 R13 queue order when filled", 1, 5, 32'h100 + i, 0, 0, 0, 0);
    end
    exec(3'd0, 3'd5, 32'h0);
    expect_out("R14 push into full queue dropped", 1, 5, 32'h0, 0, 0, 0, 1);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; prm_push = 1'b0; prm_data = '0;
    instr_valid = 1'b0; res = '0; dst = '0; mode = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mode0();
    t_mode1();
    t_mode2();
    t_mode3();
    t_mode5();
    t_mode6();
    t_mode7();
    t_wrap();
    t_r0();
    t_underflow();
    t_start();
    t_full();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule